// File: doc/BRIEF.md
# Two-Event Classification Status Tracker

This block holds the status of one power-sourcing port in a single byte: the latest classification outcome in the upper nibble and the latest detection outcome in the lower nibble. Detection and classification results arrive as one-cycle strobes, each with a 4-bit code. The measurement front end and the pulse timing are outside the block. Reserved or disallowed codes are either filtered out or mapped to a legal value before they are stored.

When two-event classification is on, the first classification result is held as pending until the second one arrives. The two are then merged into one final code. An overcurrent on the first event ends the sequence at once, and the block pulses a request to skip the second event. Two results that disagree give a class-mismatch code.

A final overcurrent or mismatch sets a sticky start-fault flag. It also stops the auto-mode power-on request from reaching the port. A manual power-enable request still goes through. A port-off strobe clears the stored status.

Top module: `pse_class_status`

## Requirements
- R1: After reset, `status_byte` is 0x00, `start_fault` is 0 and `skip_second` is 0.
- R2: The status byte has the class code in bits 7:4 and the detect code in bits 3:0. A detect strobe (`det_valid`) whose code is 0000, 0001, 0011, 0100, 0101, 0110 or 1000 is written to bits 3:0 in the cycle after the strobe.
- R3: Detect codes 1001 to 1100 are stored only while `legacy_en` is 1. When `legacy_en` is 0 these codes are ignored. Codes 0010, 0111 and 1101 to 1111 are always ignored. An ignored strobe leaves bits 3:0 unchanged.
- R4: A class strobe with code 0101 is treated as 0110 (class 0), so bits 7:4 never hold 0101. Class input codes 1000 to 1111 are ignored.
- R5: With `two_event_en` at 0, a class strobe whose `cls_second` is 0 writes its code straight to bits 7:4 one cycle later. Mismatch cannot occur in this mode.
- R6: With `two_event_en` at 1, a first-event code of 0111 (overcurrent) stores 0111. It also pulses `skip_second` for one cycle, in the cycle after the strobe. No second event is then pending, so a later second strobe is ignored.
- R7: With `two_event_en` at 1, a first-event result other than overcurrent is shown in bits 7:4 and held as pending. The following second-event strobe (`cls_second`=1) then stores a final code one cycle later:
  - 0111 if the second result is overcurrent;
  - 1000 (mismatch) if the two results differ;
  - otherwise the common code.
  A second strobe with nothing pending is ignored.
- R8: `port_off` clears both nibbles and any pending first event in the next cycle. It takes priority over result strobes in the same cycle.
- R9: Storing 0111 or 1000 in bits 7:4 sets `start_fault`, which stays set until `start_flt_clr`. When a set and a clear fall in the same cycle, the set wins.
- R10: `power_on_cmd` is 1 whenever `manual_pwr_en` is 1. Otherwise it equals `auto_mode & auto_power_req`, forced to 0 while bits 7:4 hold 0111 or 1000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_valid | input | 1 | Detection result strobe |
| det_code | input | 4 | Detection result code |
| legacy_en | input | 1 | Allows legacy/capacitance detect codes |
| cls_valid | input | 1 | Classification result strobe |
| cls_code | input | 4 | Classification result code |
| cls_second | input | 1 | Strobe carries the second event |
| two_event_en | input | 1 | Two-event classification enabled |
| port_off | input | 1 | Port turned off, clears status |
| start_flt_clr | input | 1 | Clears the start-fault flag |
| auto_mode | input | 1 | Port runs in auto mode |
| auto_power_req | input | 1 | Auto flow asks for power-on |
| manual_pwr_en | input | 1 | Manual power-enable request |
| status_byte | output | 8 | Class in 7:4, detect in 3:0 |
| skip_second | output | 1 | One-cycle request to omit the second event |
| start_fault | output | 1 | Sticky classification start-fault flag |
| power_on_cmd | output | 1 | Power-on command to the port |

## Verification
Several things can coincide in one cycle:
- the start-fault flag being set by a faulting class result and being cleared by its clear strobe;
- a port-off strobe and a result strobe.

The bench provokes the first pairing on purpose by issuing the clear in the same cycle as a second-event strobe that yields mismatch or overcurrent; the flag must stay set. It puts the second pairing into the pair sweep. A long random phase then mixes all strobes freely, and a behavioural reference model judges every output on every clock.

// File: rtl/pse_cls_pkg.sv
package pse_cls_pkg;
    localparam int CODE_W = 4;

    localparam logic [CODE_W-1:0] CLS_UNKNOWN  = 4'b0000;
    localparam logic [CODE_W-1:0] CLS_RESERVED = 4'b0101;
    localparam logic [CODE_W-1:0] CLS_ZERO     = 4'b0110;
    localparam logic [CODE_W-1:0] CLS_OVERCUR  = 4'b0111;
    localparam logic [CODE_W-1:0] CLS_MISMATCH = 4'b1000;

    localparam logic [CODE_W-1:0] DET_LEGACY_LO = 4'b1001;
    localparam logic [CODE_W-1:0] DET_LEGACY_HI = 4'b1100;

    typedef struct packed {
        logic [CODE_W-1:0] cls;
        logic [CODE_W-1:0] det;
        logic              pend;
        logic [CODE_W-1:0] first;
        logic              skip;
        logic              flt;
    } trk_state_t;
endpackage

// File: rtl/pse_det_filter.sv
module pse_det_filter
    import pse_cls_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic              legacy_en,
    output logic              accept
);
    localparam int NCODES = 1 << CODE_W;

    logic [NCODES-1:0] base_ok;
    logic [NCODES-1:0] legacy_ok;

    for (genvar i = 0; i < NCODES; i++) begin : g_mask
        localparam logic [CODE_W-1:0] CV = CODE_W'(i);
        assign base_ok[i]   = (CV == 4'b0000) || (CV == 4'b0001) ||
                              ((CV >= 4'b0011) && (CV <= 4'b0110)) ||
                              (CV == 4'b1000);
        assign legacy_ok[i] = (CV >= DET_LEGACY_LO) && (CV <= DET_LEGACY_HI);
    end

    always_comb begin
        accept = base_ok[code] || (legacy_en && legacy_ok[code]);
    end
endmodule

// File: rtl/pse_cls_merge.sv
module pse_cls_merge
    import pse_cls_pkg::*;
(
    input  logic              valid,
    input  logic [CODE_W-1:0] code,
    input  logic              second,
    input  logic              two_event_en,
    input  logic              pend_q,
    input  logic [CODE_W-1:0] first_q,
    output logic              wr,
    output logic [CODE_W-1:0] value,
    output logic              pend_set,
    output logic              pend_clr,
    output logic              skip,
    output logic              fault
);
    logic [CODE_W-1:0] norm;
    logic              measured;

    always_comb begin
        norm     = (code == CLS_RESERVED) ? CLS_ZERO : code;
        measured = (code <= CLS_OVERCUR);
        wr       = 1'b0;
        value    = CLS_UNKNOWN;
        pend_set = 1'b0;
        pend_clr = 1'b0;
        skip     = 1'b0;
        if (valid && measured) begin
            if (!second) begin
                wr       = 1'b1;
                value    = norm;
                pend_clr = 1'b1;
                if (two_event_en) begin
                    if (norm == CLS_OVERCUR) begin
                        skip = 1'b1;
                    end else begin
                        pend_set = 1'b1;
                        pend_clr = 1'b0;
                    end
                end
            end else if (pend_q) begin
                wr       = 1'b1;
                pend_clr = 1'b1;
                if (norm == CLS_OVERCUR) begin
                    value = CLS_OVERCUR;
                end else if (norm != first_q) begin
                    value = CLS_MISMATCH;
                end else begin
                    value = norm;
                end
            end
        end
        fault = wr && ((value == CLS_OVERCUR) || (value == CLS_MISMATCH));
    end
endmodule

// File: rtl/pse_class_status.sv
module pse_class_status
    import pse_cls_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              det_valid,
    input  logic [CODE_W-1:0] det_code,
    input  logic              legacy_en,
    input  logic              cls_valid,
    input  logic [CODE_W-1:0] cls_code,
    input  logic              cls_second,
    input  logic              two_event_en,
    input  logic              port_off,
    input  logic              start_flt_clr,
    input  logic              auto_mode,
    input  logic              auto_power_req,
    input  logic              manual_pwr_en,
    output logic [2*CODE_W-1:0] status_byte,
    output logic              skip_second,
    output logic              start_fault,
    output logic              power_on_cmd
);
    trk_state_t st_d, st_q;

    logic              det_ok;
    logic              m_wr, m_pset, m_pclr, m_skip, m_fault;
    logic [CODE_W-1:0] m_val;
    logic              cls_block;

    pse_det_filter u_det (
        .code      (det_code),
        .legacy_en (legacy_en),
        .accept    (det_ok)
    );

    pse_cls_merge u_merge (
        .valid        (cls_valid),
        .code         (cls_code),
        .second       (cls_second),
        .two_event_en (two_event_en),
        .pend_q       (st_q.pend),
        .first_q      (st_q.first),
        .wr           (m_wr),
        .value        (m_val),
        .pend_set     (m_pset),
        .pend_clr     (m_pclr),
        .skip         (m_skip),
        .fault        (m_fault)
    );

    always_comb begin
        st_d      = st_q;
        st_d.skip = 1'b0;
        if (port_off) begin
            st_d.cls  = '0;
            st_d.det  = '0;
            st_d.pend = 1'b0;
        end else begin
            if (det_valid && det_ok) begin
                st_d.det = det_code;
            end
            if (m_wr) begin
                st_d.cls = m_val;
            end
            if (m_pset) begin
                st_d.pend  = 1'b1;
                st_d.first = m_val;
            end else if (m_pclr) begin
                st_d.pend = 1'b0;
            end
            st_d.skip = m_skip;
        end
        if (m_fault && !port_off) begin
            st_d.flt = 1'b1;
        end else if (start_flt_clr) begin
            st_d.flt = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cls_block    = (st_q.cls == CLS_OVERCUR) || (st_q.cls == CLS_MISMATCH);
        status_byte  = {st_q.cls, st_q.det};
        skip_second  = st_q.skip;
        start_fault  = st_q.flt;
        power_on_cmd = manual_pwr_en || (auto_mode && auto_power_req && !cls_block);
    end
endmodule

// File: rtl/pse_class_status_chk.sv
module pse_class_status_chk
    import pse_cls_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              det_valid,
    input logic [CODE_W-1:0] det_code,
    input logic              legacy_en,
    input logic              cls_valid,
    input logic [CODE_W-1:0] cls_code,
    input logic              cls_second,
    input logic              two_event_en,
    input logic              port_off,
    input logic              start_flt_clr,
    input logic              manual_pwr_en,
    input logic [2*CODE_W-1:0] status_byte,
    input logic              skip_second,
    input logic              start_fault,
    input logic              power_on_cmd
);
    p_clear_on_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        port_off |=> (status_byte == 8'h00));

    p_first_oc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_valid && !cls_second && two_event_en && cls_code == CLS_OVERCUR && !port_off)
        |=> (skip_second && status_byte[7:4] == CLS_OVERCUR && start_fault));

    p_skip_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        skip_second |-> $past(cls_valid && !cls_second && two_event_en && cls_code == CLS_OVERCUR));

    p_no_reserved_r4: assert property (@(posedge clk) disable iff (!rst_n)
        status_byte[7:4] != CLS_RESERVED);

    p_legacy_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (det_valid && !legacy_en && det_code >= DET_LEGACY_LO && !port_off)
        |=> $stable(status_byte[3:0]));

    p_fault_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(start_fault) |-> $past(start_flt_clr));

    p_manual_r10: assert property (@(posedge clk) disable iff (!rst_n)
        manual_pwr_en |-> power_on_cmd);

    p_auto_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_byte[7:4] == CLS_OVERCUR || status_byte[7:4] == CLS_MISMATCH) && !manual_pwr_en)
        |-> !power_on_cmd);
endmodule

bind pse_class_status pse_class_status_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .det_valid     (det_valid),
    .det_code      (det_code),
    .legacy_en     (legacy_en),
    .cls_valid     (cls_valid),
    .cls_code      (cls_code),
    .cls_second    (cls_second),
    .two_event_en  (two_event_en),
    .port_off      (port_off),
    .start_flt_clr (start_flt_clr),
    .manual_pwr_en (manual_pwr_en),
    .status_byte   (status_byte),
    .skip_second   (skip_second),
    .start_fault   (start_fault),
    .power_on_cmd  (power_on_cmd)
);

// File: tb/pse_class_status_tb_top.sv
module pse_class_status_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       det_valid = 0, legacy_en = 0, cls_valid = 0, cls_second = 0;
    logic       two_event_en = 0, port_off = 0, start_flt_clr = 0;
    logic       auto_mode = 0, auto_power_req = 0, manual_pwr_en = 0;
    logic [3:0] det_code = 0, cls_code = 0;
    logic [7:0] status_byte;
    logic       skip_second, start_fault, power_on_cmd;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    done = 0;

    // reference model state
    int m_cls, m_det, m_first;
    bit m_pend, m_skip, m_flt;

    always #10 clk = ~clk;

    pse_class_status dut_i (
        .clk(clk), .rst_n(rst_n), .det_valid(det_valid), .det_code(det_code),
        .legacy_en(legacy_en), .cls_valid(cls_valid), .cls_code(cls_code),
        .cls_second(cls_second), .two_event_en(two_event_en), .port_off(port_off),
        .start_flt_clr(start_flt_clr), .auto_mode(auto_mode),
        .auto_power_req(auto_power_req), .manual_pwr_en(manual_pwr_en),
        .status_byte(status_byte), .skip_second(skip_second),
        .start_fault(start_fault), .power_on_cmd(power_on_cmd)
    );

    function automatic bit det_allowed(int c, bit leg);
        int allowed[$] = '{0, 1, 3, 4, 5, 6, 8};
        foreach (allowed[k]) if (allowed[k] == c) return 1;
        return leg && c >= 9 && c <= 12;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cls = 0; m_det = 0; m_first = 0; m_pend = 0; m_skip = 0; m_flt = 0;
        end else begin
            int  c;
            bit  wrote;
            wrote  = 0;
            m_skip = 0;
            if (port_off) begin
                m_cls = 0; m_det = 0; m_pend = 0;
            end else begin
                if (det_valid && det_allowed(det_code, legacy_en)) m_det = det_code;
                c = (cls_code == 5) ? 6 : int'(cls_code);
                if (cls_valid && cls_code <= 7) begin
                    if (!cls_second) begin
                        m_cls = c; wrote = 1; m_pend = 0;
                        if (two_event_en) begin
                            if (c == 7) m_skip = 1;
                            else begin m_pend = 1; m_first = c; end
                        end
                    end else if (m_pend) begin
                        m_pend = 0; wrote = 1;
                        m_cls = (c == 7) ? 7 : ((c != m_first) ? 8 : c);
                    end
                end
            end
            if (wrote && (m_cls == 7 || m_cls == 8)) m_flt = 1;
            else if (start_flt_clr) m_flt = 0;
        end
    end

    task automatic check1(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        bit exp_pwr;
        exp_pwr = manual_pwr_en || (auto_mode && auto_power_req && !(m_cls == 7 || m_cls == 8));
        check1("class nibble", status_byte[7:4], m_cls);
        check1("detect nibble", status_byte[3:0], m_det);
        check1("skip_second", skip_second, m_skip);
        check1("start_fault", start_fault, m_flt);
        check1("power_on_cmd", power_on_cmd, exp_pwr);
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        compare();
        det_valid = 0; cls_valid = 0; cls_second = 0; port_off = 0; start_flt_clr = 0;
    endtask

    task automatic cls_pulse(int code, bit second);
        cls_valid = 1; cls_code = 4'(code); cls_second = second;
        cyc();
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (2) @(negedge clk);
        compare();
        rst_n = 1;
        cyc();

        // R2 and R3: every detect code with legacy off, then on
        auto_mode = 1; auto_power_req = 1;
        for (int leg = 0; leg < 2; leg++) begin
            legacy_en = leg[0];
            for (int c = 0; c < 16; c++) begin
                cur_req = (c >= 9 || c == 2 || c == 7) ? "R3" : "R2";
                det_valid = 1; det_code = 4'(c);
                cyc();
            end
        end

        // R5 and R4: single-event mode, every input code
        two_event_en = 0;
        for (int c = 0; c < 16; c++) begin
            cur_req = (c == 5 || c > 7) ? "R4" : "R5";
            cls_pulse(c, 0);
            cls_pulse((c + 3) % 8, 1);   // second strobe without pending: ignored
            start_flt_clr = 1; cyc();
        end

        // R6 and R7: all pairs of measured codes, port-off mixed in
        two_event_en = 1;
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                cur_req = (a == 7) ? "R6" : "R7";
                cls_pulse(a, 0);
                cyc();
                cls_pulse(b, 1);
                cyc();
                start_flt_clr = 1; cyc();
                if (((a + b) % 5) == 0) begin
                    cur_req = "R8";
                    port_off = 1; cls_valid = 1; cls_code = 4'(b); det_valid = 1; det_code = 4'h4;
                    cyc();
                end
            end
        end

        // R8: port-off clears a pending first event
        cur_req = "R8";
        cls_pulse(2, 0);
        port_off = 1; cyc();
        cls_pulse(3, 1);
        cyc();

        // R9: set and clear in the same cycle, set wins
        cur_req = "R9";
        cls_pulse(1, 0);
        start_flt_clr = 1; cls_valid = 1; cls_code = 4'h2; cls_second = 1; cyc();
        cyc();
        start_flt_clr = 1; cyc();
        cls_pulse(4, 0);
        start_flt_clr = 1; cls_valid = 1; cls_code = 4'h7; cls_second = 1; cyc();

        // R10: auto gate against manual enable with a fault in the class nibble
        cur_req = "R10";
        for (int k = 0; k < 8; k++) begin
            auto_mode = k[0]; auto_power_req = k[1]; manual_pwr_en = k[2];
            cyc();
        end
        port_off = 1; cyc();
        for (int k = 0; k < 8; k++) begin
            auto_mode = k[0]; auto_power_req = k[1]; manual_pwr_en = k[2];
            cyc();
        end

        // random mix, all requirements
        cur_req = "R7";
        for (int n = 0; n < 3000; n++) begin
            det_valid      = ($urandom % 3) == 0;
            det_code       = 4'($urandom);
            legacy_en      = $urandom;
            cls_valid      = ($urandom % 2) == 0;
            cls_code       = 4'($urandom % 10);
            cls_second     = $urandom;
            two_event_en   = ($urandom % 4) != 0;
            port_off       = ($urandom % 23) == 0;
            start_flt_clr  = ($urandom % 5) == 0;
            auto_mode      = $urandom;
            auto_power_req = $urandom;
            manual_pwr_en  = ($urandom % 4) == 0;
            cyc();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule